// File: doc/BRIEF.md
# Operand Effective Address Generator

This block resolves one instruction operand in a 16/20-bit microcontroller datapath. A single-cycle `start` pulse hands it the operand mode, the operand size code, a 16-bit displacement, the value of the base register, and a few qualifiers. Immediate and register operands resolve at once. For indexed, indirect and post-increment operands the block forms a 20-bit memory address, requests the read, and holds the request until the data comes back. It then masks the returned little-endian word to the operand size.

For post-increment operands the block also produces the updated base register value. The step is 1, 2 or 4 bytes depending on size. A stack-pointer base is kept even. A write-back strobe tells the register file when to take the new value. Address arithmetic keeps the legacy 64K behaviour: an index added to a base below 64K wraps within 64K unless the extended addressing form is in use.

Register storage, the memory array and instruction decoding sit outside this block.

Top module: `opag_top`

## Requirements
- R1: After reset, `memReq`, `resultValid` and `wbEn` are all low.
- R2: Operand mode encoding is 0 immediate, 1 register, 2 indirect, 3 indirect with post-increment. In mode 0, `resultValid` is high in the cycle after the `start` edge. `result` then holds `immVal` masked to the size, and `memReq` stays low.
- R3: In mode 1, `result` is `baseVal` zero-extended and masked to the size. It is valid in the cycle after `start`, with no memory request.
- R4: In modes 2 and 3 with `noBase` low, the address is the displacement sign-extended plus `baseVal`. `memReq` rises in the cycle after `start` and stays high, with `memAddr` and `memBytes` stable, until a cycle in which `memRvalid` is high.
- R5: When `baseVal` is below 0x10000 and `extForm` is low, the indexed sum wraps to 16 bits. Otherwise the sum is only truncated to 20 bits.
- R6: With `noBase` high, the address is the 16-bit displacement zero-extended, and `baseVal` has no effect.
- R7: Size code encoding is 0 = 8 bits, 1 = 16 bits, 2 = 20 bits, 3 = 32 bits. These give `memBytes` of 1, 2, 4 and 4. The read data (byte 0 in bits 7:0) is masked to 0xFF, 0xFFFF, 0xFFFFF or all 32 bits.
- R8: In mode 3, `wbVal` is `baseVal` plus 1, 2, 4 or 4 for size codes 0..3.
- R9: In mode 3 with `baseIsSp` high, an odd incremented value is raised by one more, so the written-back stack pointer is even.
- R10: `wbEn` is high only in the `resultValid` cycle of a mode 3 access, which follows the `memRvalid` cycle. It is never high for the other modes.
- R11: A `start` pulse while an access is outstanding is ignored. The pending address, size and result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving one operand |
| mode | input | 2 | Operand mode (0 imm, 1 reg, 2 indirect, 3 post-increment) |
| sizeCode | input | 2 | Operand size (0 8-bit, 1 16-bit, 2 20-bit, 3 32-bit) |
| disp | input | 16 | Displacement or absolute address |
| baseVal | input | 20 | Base register value |
| baseIsSp | input | 1 | Base register is the stack pointer |
| extForm | input | 1 | Extended addressing form, no 64K wrap |
| noBase | input | 1 | No base register: absolute addressing |
| immVal | input | 32 | Immediate operand value |
| memReq | output | 1 | Read request, held until data returns |
| memAddr | output | 20 | Read address |
| memBytes | output | 3 | Bytes to read |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data, little-endian |
| resultValid | output | 1 | One-cycle result strobe |
| result | output | 32 | Operand value masked to size |
| wbEn | output | 1 | Base register write-back strobe |
| wbVal | output | 20 | Updated base register value |

## Verification
The hardest case to reach is a second `start` that arrives while a read is still pending. The read latency is fully under the bench's control, so the bench keeps `memRvalid` low for several cycles. During that wait it fires an immediate-mode `start` with different operands. It then checks that the address is unchanged and that the delivered result is the memory data. The wrap boundary needs a base just under 64K and a displacement that crosses it. The bench tries that sum with and without the extended form, and with a base already above 64K.

// File: rtl/opag_pkg.sv
package opag_pkg;
  typedef enum logic [1:0] {
    MODE_IMM = 2'd0,
    MODE_REG = 2'd1,
    MODE_IND = 2'd2,
    MODE_INC = 2'd3
  } opMode_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_20 = 2'd2,
    SZ_32 = 2'd3
  } opSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;      // capture operand fields at start
    logic latchDirect;  // load result from immediate/register
    logic latchRead;    // load result from memory data
  } ctrlStrobes_t;
endpackage

// File: rtl/opag_ctrl.sv
module opag_ctrl
  import opag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         memRvalid,
  output ctrlStrobes_t strb,
  output logic         memReq,
  output logic         resultValid,
  output logic         wbEn
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;

  state_e stateQ, stateD;
  logic   incQ, incD;

  always_comb begin
    stateD = stateQ;
    incD   = incQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        strb.latchOp = 1'b1;
        if (mode == MODE_IMM || mode == MODE_REG) begin
          strb.latchDirect = 1'b1;
          incD   = 1'b0;
          stateD = ST_DONE;
        end else begin
          incD   = (mode == MODE_INC);
          stateD = ST_WAIT;
        end
      end
      ST_WAIT: if (memRvalid) begin
        strb.latchRead = 1'b1;
        stateD = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      incQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      incQ   <= incD;
    end
  end

  assign memReq      = (stateQ == ST_WAIT);
  assign resultValid = (stateQ == ST_DONE);
  assign wbEn        = (stateQ == ST_DONE) && incQ;

  assert_result_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> memReq);
  assert_wb_after_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> ($past(memRvalid) && $past(memReq)));
endmodule

// File: rtl/opag_datapath.sv
module opag_datapath
  import opag_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int DISP_W   = 16,
  parameter int LEGACY_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [1:0]        mode,
  input  logic [1:0]        sizeCode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              baseIsSp,
  input  logic              extForm,
  input  logic              noBase,
  input  logic [DATA_W-1:0] immVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memBytes,
  output logic [DATA_W-1:0] result,
  output logic [ADDR_W-1:0] wbVal
);
  localparam int SUM_W = ADDR_W + 1;
  localparam logic [DATA_W-1:0] MASK8  = DATA_W'((64'd1 << 8) - 64'd1);
  localparam logic [DATA_W-1:0] MASK16 = DATA_W'((64'd1 << 16) - 64'd1);
  localparam logic [DATA_W-1:0] MASK20 = DATA_W'((64'd1 << ADDR_W) - 64'd1);

  logic [1:0]        sizeQ;
  logic [DISP_W-1:0] dispQ;
  logic [ADDR_W-1:0] baseQ;
  logic              spQ, extQ, noBaseQ;

  function automatic logic [DATA_W-1:0] maskTo(input logic [1:0] sz,
                                               input logic [DATA_W-1:0] d);
    case (sz)
      SZ_8:    return d & MASK8;
      SZ_16:   return d & MASK16;
      SZ_20:   return d & MASK20;
      default: return d;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeQ   <= '0;
      dispQ   <= '0;
      baseQ   <= '0;
      spQ     <= 1'b0;
      extQ    <= 1'b0;
      noBaseQ <= 1'b0;
      result  <= '0;
    end else begin
      if (strb.latchOp) begin
        sizeQ   <= sizeCode;
        dispQ   <= disp;
        baseQ   <= baseVal;
        spQ     <= baseIsSp;
        extQ    <= extForm;
        noBaseQ <= noBase;
      end
      if (strb.latchDirect)
        result <= maskTo(sizeCode, (mode == MODE_IMM) ? immVal : DATA_W'(baseVal));
      else if (strb.latchRead)
        result <= maskTo(sizeQ, memRdata);
    end
  end

  // effective address
  logic [SUM_W-1:0]  dispExt, indexSum;
  logic              legacyWrap;
  logic [ADDR_W-1:0] indexAddr;

  always_comb begin
    dispExt    = {{(SUM_W-DISP_W){dispQ[DISP_W-1]}}, dispQ};
    indexSum   = dispExt + {1'b0, baseQ};
    legacyWrap = !extQ && (baseQ[ADDR_W-1:LEGACY_W] == '0);
    indexAddr  = legacyWrap ? ADDR_W'(indexSum[LEGACY_W-1:0]) : indexSum[ADDR_W-1:0];
    memAddr    = noBaseQ ? ADDR_W'(dispQ) : indexAddr;
  end

  // access width and post-increment step
  logic [ADDR_W-1:0] bumped;
  always_comb begin
    case (sizeQ)
      SZ_8:    memBytes = 3'd1;
      SZ_16:   memBytes = 3'd2;
      default: memBytes = 3'd4;
    endcase
    bumped = baseQ + ADDR_W'(memBytes);
    wbVal  = (spQ && bumped[0]) ? bumped + ADDR_W'(1) : bumped;
  end

  assert_byte_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latchRead && sizeQ == SZ_8) |=> (result[DATA_W-1:8] == '0));
endmodule

// File: rtl/opag_top.sv
module opag_top
  import opag_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int DISP_W   = 16,
  parameter int LEGACY_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [1:0]        sizeCode,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic              baseIsSp,
  input  logic              extForm,
  input  logic              noBase,
  input  logic [DATA_W-1:0] immVal,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memBytes,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              resultValid,
  output logic [DATA_W-1:0] result,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal
);
  ctrlStrobes_t strb;

  opag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .memRvalid(memRvalid), .strb(strb), .memReq(memReq),
    .resultValid(resultValid), .wbEn(wbEn)
  );

  opag_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DISP_W(DISP_W), .LEGACY_W(LEGACY_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .sizeCode(sizeCode),
    .disp(disp), .baseVal(baseVal), .baseIsSp(baseIsSp), .extForm(extForm),
    .noBase(noBase), .immVal(immVal), .memRdata(memRdata),
    .memAddr(memAddr), .memBytes(memBytes), .result(result), .wbVal(wbVal)
  );

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRvalid) |=> ($stable(memAddr) && $stable(memBytes)));
  assert_byte_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ($countones(memBytes) == 1 && memBytes != 3'd0 && !memBytes[0] || memBytes == 3'd1));
endmodule

// File: tb/opag_top_tb_top.sv
module opag_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = '0;
  logic [1:0]  sizeCode = '0;
  logic [15:0] disp = '0;
  logic [19:0] baseVal = '0;
  logic        baseIsSp = 1'b0;
  logic        extForm = 1'b0;
  logic        noBase = 1'b0;
  logic [31:0] immVal = '0;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        memReq, resultValid, wbEn;
  logic [19:0] memAddr, wbVal;
  logic [2:0]  memBytes;
  logic [31:0] result;

  int nTests = 0;
  int nFail  = 0;

  always #2 clk = ~clk;  // 250 MHz

  opag_top dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .sizeCode(sizeCode),
    .disp(disp), .baseVal(baseVal), .baseIsSp(baseIsSp), .extForm(extForm),
    .noBase(noBase), .immVal(immVal), .memReq(memReq), .memAddr(memAddr),
    .memBytes(memBytes), .memRvalid(memRvalid), .memRdata(memRdata),
    .resultValid(resultValid), .result(result), .wbEn(wbEn), .wbVal(wbVal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] maskExp(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: return d & 32'hFF;
      2'd1: return d & 32'hFFFF;
      2'd2: return d & 32'hFFFFF;
      default: return d;
    endcase
  endfunction

  function automatic logic [2:0] bytesExp(input logic [1:0] sz);
    return (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  // issue start on a negedge; returns after the accepting edge, at the next negedge
  task automatic issue(input logic [1:0] m, input logic [1:0] sz, input logic [15:0] d,
                       input logic [19:0] b, input logic sp, input logic ex,
                       input logic nb, input logic [31:0] imm);
    mode = m; sizeCode = sz; disp = d; baseVal = b;
    baseIsSp = sp; extForm = ex; noBase = nb; immVal = imm; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  // respond after 'lat' waiting cycles; returns at negedge after data edge
  task automatic reply(input int lat, input logic [31:0] data);
    for (int i = 0; i < lat; i++) begin @(posedge clk); @(negedge clk); end
    memRvalid = 1'b1; memRdata = data;
    @(posedge clk); @(negedge clk);
    memRvalid = 1'b0; memRdata = '0;
  endtask

  task automatic testReset;
    check("R1 memReq", 32'(memReq), 0);
    check("R1 resultValid", 32'(resultValid), 0);
    check("R1 wbEn", 32'(wbEn), 0);
  endtask

  task automatic testImm;
    issue(2'd0, 2'd2, 16'h0, 20'h0, 0, 0, 0, 32'h12345678);
    check("R2 valid", 32'(resultValid), 1);
    check("R2 noReq", 32'(memReq), 0);
    check("R2 value", result, 32'h00045678);
    check("R10 no wb imm", 32'(wbEn), 0);
    @(negedge clk);
    check("R2 one pulse", 32'(resultValid), 0);
  endtask

  task automatic testReg;
    issue(2'd1, 2'd0, 16'h0, 20'hABCDE, 0, 0, 0, 32'h0);
    check("R3 valid", 32'(resultValid), 1);
    check("R3 byte", result, 32'hDE);
    @(negedge clk);
    issue(2'd1, 2'd3, 16'h0, 20'hABCDE, 0, 0, 0, 32'hFFFFFFFF);
    check("R3 full", result, 32'h000ABCDE);
    @(negedge clk);
  endtask

  task automatic readAddr(input string tag, input logic [15:0] d, input logic [19:0] b,
                          input logic ex, input logic nb, input logic [19:0] expA);
    issue(2'd2, 2'd1, d, b, 0, ex, nb, 32'h0);
    check({tag, " req"}, 32'(memReq), 1);
    check({tag, " addr"}, 32'(memAddr), 32'(expA));
    reply(0, 32'h0000CAFE);
    check({tag, " data"}, result, 32'hCAFE);
    check("R10 no wb plain", 32'(wbEn), 0);
    @(negedge clk);
  endtask

  task automatic testAddressing;
    readAddr("R4 neg disp", 16'hFFF0, 20'h01000, 0, 0, 20'h00FF0);
    readAddr("R5 legacy wrap", 16'h0020, 20'h0FFF0, 0, 0, 20'h00010);
    readAddr("R5 ext form", 16'h0020, 20'h0FFF0, 1, 0, 20'h10010);
    readAddr("R5 high base", 16'h0100, 20'h12345, 0, 0, 20'h12445);
    readAddr("R5 trunc20", 16'h0020, 20'hFFFF0, 0, 0, 20'h00010);
    readAddr("R6 absolute", 16'h8004, 20'h77777, 0, 1, 20'h08004);
  endtask

  task automatic testSizes;
    for (int s = 0; s < 4; s++) begin
      issue(2'd2, 2'(s), 16'h0010, 20'h00400, 0, 0, 0, 32'h0);
      check("R7 bytes", 32'(memBytes), 32'(bytesExp(2'(s))));
      reply(1, 32'hDEADBEEF);
      check("R7 mask", result, maskExp(2'(s), 32'hDEADBEEF));
      @(negedge clk);
    end
  endtask

  task automatic incCase(input string tag, input logic [1:0] sz, input logic [19:0] b,
                         input logic sp, input logic [19:0] expW);
    issue(2'd3, sz, 16'h0, b, sp, 0, 0, 32'h0);
    check("R10 no wb while waiting", 32'(wbEn), 0);
    reply(1, 32'h11223344);
    check("R10 wb with result", 32'(wbEn && resultValid), 1);
    check(tag, 32'(wbVal), 32'(expW));
    @(negedge clk);
    check("R10 wb drops", 32'(wbEn), 0);
  endtask

  task automatic testPostInc;
    incCase("R8 byte step", 2'd0, 20'h00200, 0, 20'h00201);
    incCase("R8 word step", 2'd1, 20'h00200, 0, 20'h00202);
    incCase("R8 20-bit step", 2'd2, 20'h00300, 0, 20'h00304);
    incCase("R8 32-bit step", 2'd3, 20'h00300, 0, 20'h00304);
    incCase("R9 sp byte even", 2'd0, 20'h00200, 1, 20'h00202);
    incCase("R9 sp odd base", 2'd1, 20'h00301, 1, 20'h00304);
  endtask

  task automatic testBusyStart;
    issue(2'd2, 2'd1, 16'h0004, 20'h00500, 0, 0, 0, 32'h0);
    @(negedge clk);
    issue(2'd0, 2'd3, 16'h0FFF, 20'h09999, 0, 1, 1, 32'h55555555);
    check("R11 still waiting", 32'(memReq), 1);
    check("R11 no early result", 32'(resultValid), 0);
    check("R11 addr kept", 32'(memAddr), 32'h00504);
    check("R11 size kept", 32'(memBytes), 2);
    reply(2, 32'hAAAA1234);
    check("R11 mem result", result, 32'h1234);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++; nTests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImm();
    testReg();
    testAddressing();
    testSizes();
    testPostInc();
    testBusyStart();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule